// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller

This block gathers 96 level-sensitive interrupt lines, arranged as three banks of 32, and presents two requests to a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line has a 6-bit priority and a route bit that sends it to the fast class instead of the normal class. When a class is armed and an unmasked pending line of that class exists, the block raises that class's output. In the same cycle it latches the number of the winning line as the active code.

Software reaches the block through a 32-bit register port. Requests arrive on a valid/ready channel, and each accepted request returns exactly one response on a valid/ready channel. `req_ready` is high whenever no response is waiting, or when the waiting response is taken in the same cycle (`req_ready = !rsp_valid || rsp_ready`). A response carries read data, or zero for a write, and it is held stable until `rsp_ready` is seen high.

Once a class output is raised, it stays high until software rearms that class through the control register. A rearm drops the output for one cycle, and the class is then evaluated again. Pending state is the OR of the registered line level and a per-line software-set bit.

Top module: `intc_level96`

## Requirements
- R1: After reset, the revision register (0x00) reads 0x21 and the status register (0x14) reads 1. Every bank mask reads 0xFFFFFFFF, both outputs are low, both active codes read 0 and control (0x48) reads 0.
- R2: An accepted request (`req_valid && req_ready`) produces `rsp_valid` on the next cycle. The response holds `rsp_valid` and `rsp_rdata` stable while `rsp_ready` is low, and `req_ready` is low during that time.
- R3: Bank b occupies 0x80+0x20*b. Offset +0x00 reads the registered input levels and is read-only. +0x10 ORs the written bits into the software-set bits and reads them back. +0x14 clears the written software-set bits and reads 0. Pending is the registered input OR the software-set bits.
- R4: Bank offset +0x04 writes and reads the mask (1 = masked). A write to +0x08 clears the written mask bits, and a write to +0x0C sets them. Both of these offsets read 0.
- R5: Bank offset +0x18 reads pending & ~mask & ~route, and +0x1C reads pending & ~mask & route.
- R6: When a class is armed, the global mask is off and any unmasked pending line of that class exists, the class output rises one cycle later. The winning line number is latched into that class's code register (0x40 for the normal class, 0x44 for the fast class). The output then stays high and the code stays fixed until a rearm or soft reset.
- R7: The winner is the candidate with the numerically lowest priority. Among candidates of equal priority, the highest line number wins.
- R8: A control write with bit 0 set rearms the normal class, and bit 1 rearms the fast class. The output is low in the cycle after the write and is evaluated again in the cycle after that.
- R9: Control bit 2 is the global mask. While it is set, neither output rises. Bit 2 reads back the mask state, and bits 0 and 1 read 0.
- R10: The configuration word for line n is at 0x100+4*n. Bits [7:2] hold the priority and bit 0 routes the line to the fast class (1) or the normal class (0). All other bits read 0.
- R11: In the system configuration register (0x10), bit 0 is a read/write autoidle flag. Writing 1 to bit 1 returns all state to its reset values.
- R12: The idle register (0x50) holds two read/write bits, and the protection register (0x4C) always reads 0.
- R13: Reading an active code does not clear anything. Writes to read-only or unmapped offsets change nothing. Unmapped or misaligned reads, including bank index 3 and line indices of 96 and above, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 96 | Level interrupt lines, line n on bit n |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| irq_o | output | 1 | Normal-class interrupt request |
| fiq_o | output | 1 | Fast-class interrupt request |

## Verification
The bench sweeps every one of the 96 lines alone, with every eighth line routed to the fast class. This catches a bank or index slip, which would report the wrong code or raise the wrong output. Ties of equal priority are set up on purpose: a search that kept the first match rather than the last would report the lower line. The bench rearms while lines are still active and sets the global mask together with a rearm. A design that dropped the output without evaluating again, or that let the mask leak, would either stay low or rise when it must not. The bench also checks the pending views against arithmetic over raw input, software-set, mask and route bits, and it stalls the response channel to catch a response that changes or a request taken while stalled.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_W  = 32;
  localparam int PRIO_W  = 6;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 12;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              route;
  } line_cfg_t;

  localparam logic [ADDR_W-1:0] A_REV    = 12'h000;
  localparam logic [ADDR_W-1:0] A_SYSCFG = 12'h010;
  localparam logic [ADDR_W-1:0] A_STATUS = 12'h014;
  localparam logic [ADDR_W-1:0] A_CODE_N = 12'h040;
  localparam logic [ADDR_W-1:0] A_CODE_F = 12'h044;
  localparam logic [ADDR_W-1:0] A_CTRL   = 12'h048;
  localparam logic [ADDR_W-1:0] A_IDLE   = 12'h050;
  localparam logic [ADDR_W-1:0] A_CFG0   = 12'h100;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [BANK_W-1:0] lines_i,
  input  logic [BANK_W-1:0] wdata,
  input  logic              wr_mask,
  input  logic              wr_mask_clr,
  input  logic              wr_mask_set,
  input  logic              wr_sw_set,
  input  logic              wr_sw_clr,
  output logic [BANK_W-1:0] raw_q,
  output logic [BANK_W-1:0] mask_q,
  output logic [BANK_W-1:0] sw_q,
  output logic [BANK_W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else begin
      raw_q <= lines_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else begin
      if (wr_mask)          mask_q <= wdata;
      else if (wr_mask_clr) mask_q <= mask_q & ~wdata;
      else if (wr_mask_set) mask_q <= mask_q | wdata;
      if (wr_sw_set)        sw_q   <= sw_q | wdata;
      else if (wr_sw_clr)   sw_q   <= sw_q & ~wdata;
    end
  end

  assign pend = raw_q | sw_q;
endmodule

// File: rtl/intc_pick.sv
module intc_pick
  import intc_pkg::*;
#(
  parameter int N      = 96,
  localparam int CODE_W = $clog2(N)
) (
  input  logic [N-1:0]        cand,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output logic                any,
  output logic [CODE_W-1:0]   code
);
  logic [PRIO_W-1:0] best;

  // Later lines replace an equal priority, so ties go to the highest index.
  always_comb begin
    any  = 1'b0;
    best = '1;
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] <= best)) begin
        any  = 1'b1;
        best = prio_flat[i*PRIO_W +: PRIO_W];
        code = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_slot.sv
module intc_slot #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rearm,
  input  logic              active,
  input  logic              gmask,
  input  logic [CODE_W-1:0] win_code,
  output logic              out_q,
  output logic [CODE_W-1:0] code_q
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
      code_q  <= '0;
    end else if (rearm) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
    end else if (armed_q && active && !gmask) begin
      armed_q <= 1'b0;
      out_q   <= 1'b1;
      code_q  <= win_code;
    end
  end
endmodule

// File: rtl/intc_level96.sv
module intc_level96
  import intc_pkg::*;
#(
  parameter int          BANKS    = 3,
  parameter logic [7:0]  REVISION = 8'h21,
  localparam int LINES  = BANKS * BANK_W,
  localparam int CODE_W = $clog2(LINES),
  localparam int LIDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_lines,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  // Request acceptance and address decode
  logic acc, wr, aligned, is_bank, is_line;
  logic [1:0]        bsel;
  logic [2:0]        boff;
  logic [ADDR_W-1:0] lofs;
  logic [LIDX_W-1:0] lidx;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write;
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign bsel      = req_addr[6:5];
  assign boff      = req_addr[4:2];
  assign is_bank   = aligned && (req_addr[ADDR_W-1:7] == 5'b00001) && (int'(bsel) < BANKS);
  assign lofs      = req_addr - A_CFG0;
  assign lidx      = lofs[ADDR_W-1:2];
  assign is_line   = aligned && (req_addr >= A_CFG0) && (int'(lidx) < LINES);

  logic soft_rst, wr_ctl, rearm_irq, rearm_fiq;
  assign soft_rst  = wr && aligned && (req_addr == A_SYSCFG) && req_wdata[1];
  assign wr_ctl    = wr && aligned && (req_addr == A_CTRL);
  assign rearm_irq = wr_ctl && req_wdata[0];
  assign rearm_fiq = wr_ctl && req_wdata[1];

  // Global registers
  logic       autoidle_q, gmask_q;
  logic [1:0] idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      autoidle_q <= 1'b0;
      gmask_q    <= 1'b0;
      idle_q     <= 2'b00;
    end else if (wr && aligned) begin
      if (req_addr == A_SYSCFG) autoidle_q <= req_wdata[0];
      if (req_addr == A_CTRL)   gmask_q    <= req_wdata[2];
      if (req_addr == A_IDLE)   idle_q     <= req_wdata[1:0];
    end
  end

  // Per-line configuration
  line_cfg_t             cfg_q [LINES];
  logic [LINES-1:0]      route_all;
  logic [LINES*PRIO_W-1:0] prio_flat;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      for (int i = 0; i < LINES; i++) cfg_q[i] <= '0;
    end else if (wr && is_line) begin
      cfg_q[lidx[CODE_W-1:0]] <= '{prio: req_wdata[PRIO_W+1:2], route: req_wdata[0]};
    end
  end

  // Banks
  logic [BANK_W-1:0] raw_b [BANKS];
  logic [BANK_W-1:0] mask_b[BANKS];
  logic [BANK_W-1:0] sw_b  [BANKS];
  logic [BANK_W-1:0] pend_b[BANKS];
  logic [LINES-1:0]  pend_all, mask_all;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr && is_bank && (int'(bsel) == b);
    intc_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (soft_rst),
      .lines_i    (irq_lines[b*BANK_W +: BANK_W]),
      .wdata      (req_wdata),
      .wr_mask    (hit && boff == 3'd1),
      .wr_mask_clr(hit && boff == 3'd2),
      .wr_mask_set(hit && boff == 3'd3),
      .wr_sw_set  (hit && boff == 3'd4),
      .wr_sw_clr  (hit && boff == 3'd5),
      .raw_q      (raw_b[b]),
      .mask_q     (mask_b[b]),
      .sw_q       (sw_b[b]),
      .pend       (pend_b[b])
    );
    assign pend_all[b*BANK_W +: BANK_W] = pend_b[b];
    assign mask_all[b*BANK_W +: BANK_W] = mask_b[b];
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign route_all[i]                 = cfg_q[i].route;
    assign prio_flat[i*PRIO_W +: PRIO_W] = cfg_q[i].prio;
  end

  // Two request classes: index 0 normal, index 1 fast
  logic [LINES-1:0]  cand   [2];
  logic              any_c  [2];
  logic [CODE_W-1:0] win_c  [2];
  logic [CODE_W-1:0] code_c [2];
  logic              out_c  [2];
  logic              rearm_c[2];

  assign cand[0]    = pend_all & ~mask_all & ~route_all;
  assign cand[1]    = pend_all & ~mask_all &  route_all;
  assign rearm_c[0] = rearm_irq;
  assign rearm_c[1] = rearm_fiq;

  for (genvar c = 0; c < 2; c++) begin : g_class
    intc_pick #(.N(LINES)) u_pick (
      .cand     (cand[c]),
      .prio_flat(prio_flat),
      .any      (any_c[c]),
      .code     (win_c[c])
    );
    intc_slot #(.CODE_W(CODE_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_rst),
      .rearm   (rearm_c[c]),
      .active  (any_c[c]),
      .gmask   (gmask_q),
      .win_code(win_c[c]),
      .out_q   (out_c[c]),
      .code_q  (code_c[c])
    );
  end

  assign irq_o = out_c[0];
  assign fiq_o = out_c[1];

  logic [CODE_W-1:0] irq_code_q;
  assign irq_code_q = code_c[0];

  // Read mux
  logic [WORD_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (is_bank) begin
      case (boff)
        3'd0:    rd_next = raw_b[bsel];
        3'd1:    rd_next = mask_b[bsel];
        3'd4:    rd_next = sw_b[bsel];
        3'd6:    rd_next = pend_b[bsel] & ~mask_b[bsel] & ~route_all[int'(bsel)*BANK_W +: BANK_W];
        3'd7:    rd_next = pend_b[bsel] & ~mask_b[bsel] &  route_all[int'(bsel)*BANK_W +: BANK_W];
        default: rd_next = '0;
      endcase
    end else if (is_line) begin
      rd_next = WORD_W'({cfg_q[lidx[CODE_W-1:0]].prio, 1'b0, cfg_q[lidx[CODE_W-1:0]].route});
    end else if (aligned) begin
      case (req_addr)
        A_REV:    rd_next = WORD_W'(REVISION);
        A_SYSCFG: rd_next = WORD_W'(autoidle_q);
        A_STATUS: rd_next = 32'd1;
        A_CODE_N: rd_next = WORD_W'(code_c[0]);
        A_CODE_F: rd_next = WORD_W'(code_c[1]);
        A_CTRL:   rd_next = WORD_W'({gmask_q, 2'b00});
        A_IDLE:   rd_next = WORD_W'(idle_q);
        default:  rd_next = '0;
      endcase
    end
  end

  // Response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_level96_chk.sv
module intc_level96_chk #(
  parameter int LINES  = 96,
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              gmask_q,
  input logic              rearm_irq,
  input logic              rearm_fiq,
  input logic              soft_rst,
  input logic [CODE_W-1:0] irq_code_q
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R2
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R2
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !rearm_irq && !soft_rst |=> irq_o); // R6
  AST_CODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !soft_rst |=> $stable(irq_code_q)); // R6
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(irq_code_q) < LINES); // R7
  AST_REARM_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_irq |=> !irq_o); // R8
  AST_REARM_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_fiq |=> !fiq_o); // R8
  AST_GMASK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(!gmask_q)); // R9
  AST_GMASK_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(!gmask_q)); // R9
endmodule

bind intc_level96 intc_level96_chk #(.LINES(LINES), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .gmask_q   (gmask_q),
  .rearm_irq (rearm_irq),
  .rearm_fiq (rearm_fiq),
  .soft_rst  (soft_rst),
  .irq_code_q(irq_code_q)
);

// File: tb/intc_level96_bench.sv
module intc_level96_bench;
  localparam int LINES = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [LINES-1:0] irq_lines = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  intc_level96 u_intc_level96 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r;
    bus(1'b1, a, d, r);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] r;
    bus(1'b0, a, 32'd0, r);
    chk(req, r, exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 revision", 12'h000, 32'h21);
    rd_chk("R1 status", 12'h014, 32'd1);
    for (int b = 0; b < 3; b++) rd_chk("R1 mask", 12'(12'h084 + 32 * b), 32'hFFFF_FFFF);
    rd_chk("R1 code", 12'h040, 32'd0);
    rd_chk("R1 control", 12'h048, 32'd0);
    chk("R1 outputs", {30'd0, irq_o, fiq_o}, 32'd0);

    // R12, R11 simple registers
    wr(12'h050, 32'h7);  rd_chk("R12 idle", 12'h050, 32'h3);
    wr(12'h04C, 32'h1);  rd_chk("R12 protection", 12'h04C, 32'h0);
    wr(12'h010, 32'h1);  rd_chk("R11 autoidle", 12'h010, 32'h1);

    // R13 read-only / unmapped
    wr(12'h000, 32'h55);      rd_chk("R13 rev write ignored", 12'h000, 32'h21);
    wr(12'h080, 32'hFFFF_FFFF); rd_chk("R13 raw write ignored", 12'h080, 32'h0);
    wr(12'h0E4, 32'h0);       rd_chk("R13 bank3 read", 12'h0E4, 32'h0);
    rd_chk("R13 mask0 after bank3 write", 12'h084, 32'hFFFF_FFFF);
    rd_chk("R13 line 96 read", 12'h280, 32'h0);
    rd_chk("R13 misaligned", 12'h086, 32'h0);

    // Sweep every line; lines with n%8==3 go to the fast class (R6, R8, R10)
    for (int b = 0; b < 3; b++) wr(12'(12'h088 + 32 * b), 32'hFFFF_FFFF);
    for (int n = 3; n < LINES; n += 8) wr(12'(12'h100 + 4 * n), 32'h1);
    for (int n = 0; n < LINES; n++) begin
      logic fast;
      fast = (n % 8 == 3);
      irq_lines = '0;
      irq_lines[n] = 1'b1;
      settle();
      chk($sformatf("R6 line %0d irq", n), {31'd0, irq_o}, {31'd0, !fast});
      chk($sformatf("R10 line %0d fiq", n), {31'd0, fiq_o}, {31'd0, fast});
      rd_chk("R6 code", fast ? 12'h044 : 12'h040, n);
      rd_chk("R13 code reread", fast ? 12'h044 : 12'h040, n);
      irq_lines = '0;
      repeat (2) @(negedge clk);
      wr(12'h048, fast ? 32'h2 : 32'h1);
      chk("R8 dropped", {30'd0, irq_o, fiq_o}, 32'd0);
      settle();
      chk("R8 stays low when idle", {30'd0, irq_o, fiq_o}, 32'd0);
    end

    // R7 priority and ties
    wr(12'h114, 32'h0C); wr(12'h1A0, 32'h0C); wr(12'h268, 32'h1C);
    irq_lines = '0; irq_lines[5] = 1'b1; irq_lines[40] = 1'b1; irq_lines[90] = 1'b1;
    settle();
    rd_chk("R7 tie to higher line", 12'h040, 32'd40);
    wr(12'h268, 32'h04); wr(12'h048, 32'h1); settle();
    chk("R8 rearm with active line", {31'd0, irq_o}, 32'd1);
    rd_chk("R7 lowest priority", 12'h040, 32'd90);
    wr(12'h114, 32'h04); wr(12'h268, 32'h08); wr(12'h048, 32'h1); settle();
    rd_chk("R7 new winner", 12'h040, 32'd5);

    // R9 global mask
    wr(12'h048, 32'h5); settle();
    chk("R9 masked", {31'd0, irq_o}, 32'd0);
    rd_chk("R9 readback", 12'h048, 32'h4);
    wr(12'h048, 32'h0); settle();
    chk("R9 unmasked", {31'd0, irq_o}, 32'd1);
    rd_chk("R9 code", 12'h040, 32'd5);
    irq_lines = '0;
    repeat (2) @(negedge clk);
    wr(12'h048, 32'h3);

    // R3 R4 R5 pending views in bank 1
    wr(12'h190, 32'h1); wr(12'h1A4, 32'hAB);
    rd_chk("R10 config readback", 12'h1A4, 32'hA9);
    wr(12'h0A4, 32'h0000_FF00);
    wr(12'h0B0, 32'h0000_0F30);
    irq_lines[33] = 1'b1; settle();
    rd_chk("R3 raw", 12'h0A0, 32'h2);
    rd_chk("R3 sw set", 12'h0B0, 32'h0F30);
    rd_chk("R3 sw clr reads 0", 12'h0B4, 32'h0);
    rd_chk("R5 pending normal", 12'h0B8, 32'h22);
    rd_chk("R5 pending fast", 12'h0BC, 32'h10);
    wr(12'h0B4, 32'h0F30);
    rd_chk("R3 after sw clear", 12'h0B8, 32'h2);
    rd_chk("R3 fast after clear", 12'h0BC, 32'h0);
    wr(12'h0AC, 32'h3);  rd_chk("R4 mask set", 12'h0A4, 32'h0000_FF03);
    wr(12'h0A8, 32'hFF00); rd_chk("R4 mask clear", 12'h0A4, 32'h3);
    rd_chk("R4 clear reads 0", 12'h0A8, 32'h0);
    rd_chk("R4 set reads 0", 12'h0AC, 32'h0);
    rd_chk("R3 raw masked still raw", 12'h0A0, 32'h2);
    irq_lines = '0;

    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h000;
    @(negedge clk);
    req_addr = 12'h014;
    chk("R2 valid", {31'd0, rsp_valid}, 32'd1);
    chk("R2 ready low", {31'd0, req_ready}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R2 held data", rsp_rdata, 32'h21);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 next data", rsp_rdata, 32'd1);

    // R11 soft reset
    wr(12'h010, 32'h2);
    rd_chk("R11 mask", 12'h0A4, 32'hFFFF_FFFF);
    rd_chk("R11 config", 12'h1A4, 32'h0);
    rd_chk("R11 autoidle", 12'h010, 32'h0);
    rd_chk("R11 idle", 12'h050, 32'h0);
    rd_chk("R11 code", 12'h040, 32'h0);
    chk("R11 outputs", {30'd0, irq_o, fiq_o}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule